// File: doc/BRIEF.md
# Reset and Low-Power State Controller

This block produces the internal reset of a small 8-bit microcontroller and runs its two low-power states. It watches an external active-high reset pin, a brown-out flag from an analog supply monitor, the low-power request bits written by the CPU, and a strobe that says some enabled interrupt is pending. From these it drives the internal reset, gating enables for the CPU clock, the peripheral clock and the oscillator, and a per-pin force-high vector for the I/O ports.

A reset from the pin is taken only after the pin has stayed high for two machine cycles of twelve oscillator clocks each. The ports, however, go high the moment the pin rises. When the brown-out flag is active, every port pin except the two analog comparator inputs is pulled high. When the flag drops, the block holds the internal reset for a parameterised number of clocks. The default is 180000 clocks, which is 15 ms at 12 MHz.

The two request bits live in this block. Bit 0 requests idle and bit 1 requests power-down. A CPU write is accepted only while the CPU clock runs. An enabled interrupt ends idle. Power-down ends only through a reset. The bits clear themselves on the way out. All logic runs on a free-running clock that power-down does not stop.

Top module: `rst_pwr_ctrl`

## Requirements
- R1: `sys_rst_o` rises after the 24th consecutive rising clock edge at which `rst_pin_i` is sampled high, and not before. A high pulse covering only 23 edges causes no reset.
- R2: While `rst_pin_i` is high, every bit of `port_hi_o` is 1 combinationally, before any qualification. While `sys_rst_o` is high, every bit is also 1.
- R3: In idle (request bits = 01), `cpu_clk_en_o` is 0 while `per_clk_en_o` and `osc_en_o` stay 1. An `irq_i` at an edge returns the bits to 00 and turns `cpu_clk_en_o` back to 1.
- R4: In power-down (bit 1 set), `cpu_clk_en_o`, `per_clk_en_o` and `osc_en_o` are all 0. `irq_i` has no effect on this state.
- R5: While `bod_i` is high, `port_hi_o` has 1 in every bit outside `CMP_MASK` and 0 in the bits of `CMP_MASK` (default 8'h03, pins 0 and 1), unless R2 applies.
- R6: After the edge at which `bod_i` is first sampled low following a high, `sys_rst_o` is high for exactly `BOD_DLY` clock cycles.
- R7: An edge that sees `sys_rst_o` high clears the request bits (`pcon_o`) to 00, which leaves power-down and idle.
- R8: When a write sets both request bits (11), power-down behaviour wins: all three enables are 0.
- R9: A write (`pcon_we_i`) is taken only when `pcon_o` is 00. Writes in idle or power-down leave `pcon_o` unchanged.
- R10: `osc_en_o` is 1 whenever `rst_pin_i` is high, even in power-down, so that the pin can be qualified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| rst_pin_i | input | 1 | External reset pin, active high |
| bod_i | input | 1 | Brown-out flag, active high |
| pcon_we_i | input | 1 | CPU write strobe for the request bits |
| pcon_wd_i | input | 2 | Write data: bit 0 requests idle, bit 1 requests power-down |
| irq_i | input | 1 | Some enabled interrupt is pending |
| sys_rst_o | output | 1 | Internal reset, active high |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Timer, serial and interrupt clock enable |
| osc_en_o | output | 1 | Oscillator run enable |
| port_hi_o | output | PORT_W | Per-pin force-high |
| pcon_o | output | 2 | Current request bits |

## Verification
The bench drives a reset-pin pulse that covers one edge fewer than the qualification count. A controller that counts one short would reset on it, and one that ignores the count would drop the idle state. It raises an interrupt during power-down, where a controller with the wrong wake rule would restart the clocks, and it sets both request bits at once to catch a priority that lets idle win. It times the brown-out hold to the exact first and last cycle. It checks that the comparator pins stay free during brown-out and that the oscillator enable returns as soon as the pin rises out of power-down.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int unsigned MC_CLKS  = 12;
  localparam int unsigned QUAL_MCS = 2;
  typedef struct packed {
    logic pd;
    logic idle;
  } pcon_t;
endpackage

// File: rtl/rst_qual.sv
module rst_qual #(
  parameter int unsigned QUAL = 24,
  localparam int unsigned CW  = $clog2(QUAL + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic qual_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!pin_i)                 cnt_q <= '0;
    else if (cnt_q != CW'(QUAL))     cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == CW'(QUAL));

  // R1: a low pin drops the qualified reset on the next edge
  a_r1_low_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_i |=> !qual_o);
  // R1: the qualified reset only ever rises with the pin held high
  a_r1_rise_needs_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!qual_o && !pin_i) |=> !qual_o);
endmodule

// File: rtl/bod_hold.sv
module bod_hold #(
  parameter int unsigned DLY = 180000,
  localparam int unsigned CW = $clog2(DLY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bod_i,
  output logic busy_o
);
  logic          bod_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bod_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      bod_q <= bod_i;
      if (bod_q && !bod_i)    cnt_q <= CW'(DLY);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);

  // R6: recovery from brown-out starts the hold on the following cycle
  a_r6_fall_starts_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bod_q && !bod_i) |=> busy_o);
  // R6: the hold never restarts without a brown-out fall
  a_r6_no_spurious_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(bod_q && !bod_i)) |=> !busy_o);
endmodule

// File: rtl/pwr_state.sv
module pwr_state
  import rpc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sys_rst_i,
  input  logic       we_i,
  input  logic [1:0] wd_i,
  input  logic       irq_i,
  output pcon_t      pcon_o
);
  pcon_t pcon_q;
  logic  run;

  assign run = !pcon_q.pd && !pcon_q.idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          pcon_q <= '0;
    else if (sys_rst_i)                   pcon_q <= '0;
    else if (run && we_i)                 pcon_q <= pcon_t'(wd_i);
    else if (!pcon_q.pd && pcon_q.idle && irq_i) pcon_q <= '0;
  end

  assign pcon_o = pcon_q;

  // R4: only reset leaves power-down
  a_r4_pd_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcon_q.pd && !sys_rst_i) |=> pcon_q.pd);
  // R3: an interrupt wakes idle
  a_r3_idle_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pcon_q.pd && pcon_q.idle && irq_i && !sys_rst_i) |=> (pcon_q == '0));
  // R7: reset clears the request bits
  a_r7_rst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> (pcon_q == '0));
  // R9: writes outside run leave the bits alone
  a_r9_lp_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && we_i && !irq_i && !sys_rst_i) |=> $stable(pcon_q));
endmodule

// File: rtl/rst_pwr_ctrl.sv
module rst_pwr_ctrl
  import rpc_pkg::*;
#(
  parameter int unsigned         PORT_W   = 8,
  parameter logic [PORT_W-1:0]   CMP_MASK = 8'h03,
  parameter int unsigned         BOD_DLY  = 180000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_i,
  input  logic              bod_i,
  input  logic              pcon_we_i,
  input  logic [1:0]        pcon_wd_i,
  input  logic              irq_i,
  output logic              sys_rst_o,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              osc_en_o,
  output logic [PORT_W-1:0] port_hi_o,
  output logic [1:0]        pcon_o
);
  localparam int unsigned QUAL = MC_CLKS * QUAL_MCS;

  logic  pin_ok, bod_busy;
  pcon_t pcon;

  rst_qual #(.QUAL(QUAL)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(rst_pin_i), .qual_o(pin_ok));

  bod_hold #(.DLY(BOD_DLY)) u_bod (
    .clk_i(clk_i), .rst_ni(rst_ni), .bod_i(bod_i), .busy_o(bod_busy));

  assign sys_rst_o = pin_ok || bod_busy;

  pwr_state u_pwr (
    .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_i(sys_rst_o),
    .we_i(pcon_we_i), .wd_i(pcon_wd_i), .irq_i(irq_i), .pcon_o(pcon));

  assign pcon_o       = pcon;
  // power-down wins over idle
  assign cpu_clk_en_o = !pcon.pd && !pcon.idle;
  assign per_clk_en_o = !pcon.pd;
  assign osc_en_o     = !pcon.pd || rst_pin_i;

  for (genvar i = 0; i < PORT_W; i++) begin : g_port
    assign port_hi_o[i] = rst_pin_i || sys_rst_o || (bod_i && !CMP_MASK[i]);
  end

  // R8: both bits set means every clock is off
  a_r8_pd_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcon.pd && pcon.idle && !rst_pin_i) |-> (!cpu_clk_en_o && !per_clk_en_o && !osc_en_o));
  // R2: ports are all high while the pin is high
  a_r2_pin_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pin_i |-> (&port_hi_o));
endmodule

// File: tb/sim_rst_pwr_ctrl.sv
module sim_rst_pwr_ctrl;
  localparam int DLY = 50;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 0, bod = 0, we = 0, irq = 0;
  logic [1:0] wd = 0;
  logic sys_rst, cpu_en, per_en, osc_en;
  logic [7:0] port_hi;
  logic [1:0] pcon;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rst_pwr_ctrl #(.PORT_W(8), .CMP_MASK(8'h03), .BOD_DLY(DLY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rst_pin_i(pin), .bod_i(bod),
    .pcon_we_i(we), .pcon_wd_i(wd), .irq_i(irq), .sys_rst_o(sys_rst),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .osc_en_o(osc_en),
    .port_hi_o(port_hi), .pcon_o(pcon));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic edge_wait();
    @(posedge clk); #1;
  endtask

  // {we, wd, irq, exp_pcon, exp_cpu, exp_per, exp_osc}
  typedef logic [8:0] vec_t;
  localparam vec_t VEC [8] = '{
    {1'b1, 2'b01, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1},  // R3 enter idle
    {1'b1, 2'b00, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1},  // R9 write in idle ignored
    {1'b0, 2'b00, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1},  // R3 irq wakes idle
    {1'b0, 2'b00, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1},  // R3 irq in run: no change
    {1'b1, 2'b10, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0},  // R4 enter power-down
    {1'b0, 2'b00, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0},  // R4 irq ignored
    {1'b1, 2'b00, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0},  // R9 write in pd ignored
    {1'b0, 2'b00, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0}   // R4 stays
  };

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #20 rst_n = 1'b1;
    edge_wait();
    // reset state
    chk("R7 reset pcon", 16'(pcon), 16'h0);
    chk("R3 reset cpu_en", 16'(cpu_en), 16'h1);
    chk("R1 reset sys_rst", 16'(sys_rst), 16'h0);
    chk("R2 reset ports", 16'(port_hi), 16'h00);

    foreach (VEC[i]) begin
      @(negedge clk);
      {we, wd, irq} = VEC[i][8:5];
      edge_wait();
      chk($sformatf("R3/R4/R9 vec%0d pcon", i), 16'(pcon), 16'(VEC[i][4:3]));
      chk($sformatf("R3/R4 vec%0d en", i), 16'({cpu_en, per_en, osc_en}), 16'(VEC[i][2:0]));
    end
    @(negedge clk); we = 0; irq = 0;

    // R10 / R2: pin rises in power-down
    pin = 1; #1;
    chk("R2 immediate port force", 16'(port_hi), 16'hFF);
    chk("R10 osc restarts", 16'(osc_en), 16'h1);
    chk("R1 no immediate reset", 16'(sys_rst), 16'h0);
    for (int k = 1; k <= 23; k++) edge_wait();
    chk("R1 no reset after 23", 16'(sys_rst), 16'h0);
    chk("R4 pd still set before reset", 16'(pcon), 16'h2);
    edge_wait();
    chk("R1 reset after 24", 16'(sys_rst), 16'h1);
    edge_wait();
    chk("R7 reset clears pd", 16'(pcon), 16'h0);
    @(negedge clk); pin = 0;
    edge_wait();
    chk("R1 reset release", 16'(sys_rst), 16'h0);
    chk("R2 ports released", 16'(port_hi), 16'h00);

    // R1: 23-edge pulse is ignored; idle survives
    @(negedge clk); we = 1; wd = 2'b01;
    edge_wait();
    @(negedge clk); we = 0; pin = 1;
    begin
      logic seen = 0;
      for (int k = 1; k <= 23; k++) begin edge_wait(); seen |= sys_rst; end
      @(negedge clk); pin = 0;
      edge_wait(); seen |= sys_rst;
      chk("R1 short pulse no reset", 16'(seen), 16'h0);
    end
    chk("R1 short pulse keeps idle", 16'(pcon), 16'h1);
    @(negedge clk); irq = 1;
    edge_wait();
    @(negedge clk); irq = 0;

    // R8: both bits
    we = 1; wd = 2'b11;
    edge_wait();
    @(negedge clk); we = 0; irq = 1;
    edge_wait();
    chk("R8 both bits kept", 16'(pcon), 16'h3);
    chk("R8 pd wins", 16'({cpu_en, per_en, osc_en}), 16'h0);
    @(negedge clk); irq = 0;

    // R5 / R6: brown-out
    bod = 1; #1;
    chk("R5 comparator pins free", 16'(port_hi), 16'hFC);
    chk("R5 no reset during bod", 16'(sys_rst), 16'h0);
    edge_wait(); edge_wait();
    @(negedge clk); bod = 0;
    edge_wait();
    chk("R6 hold starts", 16'(sys_rst), 16'h1);
    chk("R2 ports high in hold", 16'(port_hi), 16'hFF);
    for (int k = 2; k <= DLY; k++) edge_wait();
    chk("R6 hold last cycle", 16'(sys_rst), 16'h1);
    chk("R7 bod reset clears bits", 16'(pcon), 16'h0);
    edge_wait();
    chk("R6 hold ends", 16'(sys_rst), 16'h0);
    chk("R3 cpu runs after hold", 16'(cpu_en), 16'h1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule